// File: doc/BRIEF.md
# DCT Watermark Block Sequencer

This block is the controller of a watermarking unit that handles an image one 8x8 block at a time. It fetches the block row by row into the input register of a pipelined row transform. After each row it returns to its load state, until all rows have passed that first stage. It then starts the column transform, which is fed in parallel from a transpose buffer. It captures the two-dimensional coefficients and steps through every coefficient while the external insertion datapath writes watermarked values out. The transforms, the transpose buffer and the arithmetic are outside the block. The sequencer talks to them through start pulses and done inputs, and it owns the row, coefficient and block counters that index them.

The six states are held one-hot: LOAD (S0), ROW_GO (S1), ROW_WAIT (S2), COL (S3), CAPTURE (S4) and INSERT (S5). The transitions are as follows:
- LOAD to ROW_GO on `src_valid`.
- ROW_GO to ROW_WAIT unconditionally.
- ROW_WAIT back to LOAD on `row_done` for any row but the last, and ROW_WAIT to COL on `row_done` for the last row.
- COL to CAPTURE on `col_done`.
- CAPTURE to INSERT unconditionally.
- INSERT back to LOAD after the last coefficient.

Any code that is not one of the six states falls back to LOAD.

Top module: `wm_blk_seq`

## Requirements
- R1: After reset the block is in LOAD. Every strobe (`ld_row`, `row_start`, `col_start`, `coef_cap`, `wm_we`, `block_done`, `frame_done`) is low, and `row_idx` and `coef_idx` are 0.
- R2: In LOAD with `src_valid` low, the block stays in LOAD and raises no strobe. In a LOAD cycle with `src_valid` high, `ld_row` is high in that same cycle, `row_idx` gives the row being fetched, and the next state is ROW_GO.
- R3: ROW_GO lasts exactly one cycle, with `row_start` high, and is followed by ROW_WAIT.
- R4: ROW_WAIT holds, with no strobe, until `row_done` is high. For rows 0 to 6, `row_done` increments `row_idx` and returns the block to LOAD. For row 7, it clears `row_idx` to 0 and moves to COL.
- R5: `row_done` is acted on only in ROW_WAIT, and `col_done` only in COL. In any other state they change neither the state nor the counters.
- R6: `col_start` is high only in the first cycle of COL. The block then stays in COL, with no strobe, until `col_done` is high, and moves on to CAPTURE.
- R7: CAPTURE lasts one cycle, with `coef_cap` high, and is followed by INSERT.
- R8: INSERT lasts exactly 64 cycles. `wm_we` is high in each of them, and `coef_idx` runs 0, 1, ..., 63 in ascending order. The block then returns to LOAD.
- R9: `block_done` is high only in the last INSERT cycle, which is the cycle of the move back to LOAD.
- R10: `frame_done` is high together with `block_done` on every `frame_blocks`-th completed block, after which the block count restarts. A `frame_blocks` value of 0 stands for 2^BLK_W blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | A pixel row is available in storage |
| row_done | input | 1 | The row transform has finished the current row |
| col_done | input | 1 | The column transform has finished the block |
| frame_blocks | input | BLK_W | Blocks per frame (0 means 2^BLK_W) |
| ld_row | output | 1 | Load the current row into the input register |
| row_idx | output | ROW_W | Index of the row being loaded or transformed |
| row_start | output | 1 | Single-cycle start for the row transform |
| col_start | output | 1 | Single-cycle start for the column transform |
| coef_cap | output | 1 | Capture the 2D coefficients |
| wm_we | output | 1 | Write enable for a watermarked coefficient |
| coef_idx | output | COEF_W | Index of the coefficient being written |
| block_done | output | 1 | Last write cycle of a block |
| frame_done | output | 1 | Last write cycle of the final block of a frame |

## Verification
The checks take for granted that `col_done` never arrives in the same cycle as `col_start`. They also assume that `frame_blocks` changes only when a frame has just completed. The bench raises `col_done` at least one cycle after the column start. It reprograms `frame_blocks` only after the block that carried `frame_done`. It drives spurious done inputs only in states where they are meant to be ignored. Within those limits, the latencies of the source, the row engine and the column engine vary from row to row and from block to block.

// File: rtl/wm_seq_pkg.sv
package wm_seq_pkg;

    typedef enum logic [5:0] {
        ST_LOAD     = 6'b000001,
        ST_ROW_GO   = 6'b000010,
        ST_ROW_WAIT = 6'b000100,
        ST_COL      = 6'b001000,
        ST_CAPTURE  = 6'b010000,
        ST_INSERT   = 6'b100000
    } seq_state_e;

    typedef struct packed {
        logic ld_row;
        logic row_start;
        logic col_start;
        logic coef_cap;
        logic wm_we;
    } seq_strobe_t;

endpackage

// File: rtl/wm_seq_cnt.sv
module wm_seq_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/wm_seq_fsm.sv
module wm_seq_fsm
    import wm_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        src_valid,
    input  logic        row_done,
    input  logic        col_done,
    input  logic        row_last,
    input  logic        coef_last,
    output seq_strobe_t strb,
    output logic        row_adv,
    output logic        blk_end
);

    seq_state_e state;
    seq_state_e nxt;
    logic       col_issued;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= nxt;
        end
    end

    // remembers that the column start has already gone out in this COL visit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_issued <= 1'b0;
        end else begin
            col_issued <= (state == ST_COL) && (nxt == ST_COL);
        end
    end

    // next state; done inputs are looked at only in their own wait state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOAD:     if (src_valid) nxt = ST_ROW_GO;
            ST_ROW_GO:   nxt = ST_ROW_WAIT;
            ST_ROW_WAIT: if (row_done) nxt = row_last ? ST_COL : ST_LOAD;
            ST_COL:      if (col_done) nxt = ST_CAPTURE;
            ST_CAPTURE:  nxt = ST_INSERT;
            ST_INSERT:   if (coef_last) nxt = ST_LOAD;
            default:     nxt = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        strb    = '0;
        row_adv = 1'b0;
        blk_end = 1'b0;
        unique case (state)
            ST_LOAD:     strb.ld_row    = src_valid;
            ST_ROW_GO:   strb.row_start = 1'b1;
            ST_ROW_WAIT: row_adv        = row_done;
            ST_COL:      strb.col_start = !col_issued;
            ST_CAPTURE:  strb.coef_cap  = 1'b1;
            ST_INSERT: begin
                strb.wm_we = 1'b1;
                blk_end    = coef_last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wm_blk_seq.sv
module wm_blk_seq
    import wm_seq_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COEFS = 64,
    parameter int BLK_W = 4,
    localparam int ROW_W  = (ROWS  > 1) ? $clog2(ROWS)  : 1,
    localparam int COEF_W = (COEFS > 1) ? $clog2(COEFS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic              row_done,
    input  logic              col_done,
    input  logic [BLK_W-1:0]  frame_blocks,
    output logic              ld_row,
    output logic [ROW_W-1:0]  row_idx,
    output logic              row_start,
    output logic              col_start,
    output logic              coef_cap,
    output logic              wm_we,
    output logic [COEF_W-1:0] coef_idx,
    output logic              block_done,
    output logic              frame_done
);

    seq_strobe_t      strb;
    logic             row_adv;
    logic             blk_end;
    logic             row_last;
    logic             coef_last;
    logic             blk_last;
    logic [BLK_W-1:0] blk_cnt;

    assign row_last  = (row_idx == ROW_W'(ROWS - 1));
    assign coef_last = (coef_idx == COEF_W'(COEFS - 1));
    // wraps, so a programmed 0 means a full 2^BLK_W blocks
    assign blk_last  = ((blk_cnt + BLK_W'(1)) == frame_blocks);

    wm_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .row_done  (row_done),
        .col_done  (col_done),
        .row_last  (row_last),
        .coef_last (coef_last),
        .strb      (strb),
        .row_adv   (row_adv),
        .blk_end   (blk_end)
    );

    wm_seq_cnt #(.W(ROW_W)) u_row_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (row_adv && row_last),
        .inc   (row_adv),
        .cnt   (row_idx)
    );

    wm_seq_cnt #(.W(COEF_W)) u_coef_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (strb.wm_we && coef_last),
        .inc   (strb.wm_we),
        .cnt   (coef_idx)
    );

    wm_seq_cnt #(.W(BLK_W)) u_blk_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (blk_end && blk_last),
        .inc   (blk_end),
        .cnt   (blk_cnt)
    );

    assign ld_row     = strb.ld_row;
    assign row_start  = strb.row_start;
    assign col_start  = strb.col_start;
    assign coef_cap   = strb.coef_cap;
    assign wm_we      = strb.wm_we;
    assign block_done = blk_end;
    assign frame_done = blk_end && blk_last;

endmodule

// File: rtl/wm_blk_seq_chk.sv
module wm_blk_seq_chk #(
    parameter int COEFS  = 64,
    parameter int COEF_W = 6,
    parameter int ROW_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              col_done,
    input logic              ld_row,
    input logic [ROW_W-1:0]  row_idx,
    input logic              row_start,
    input logic              col_start,
    input logic              coef_cap,
    input logic              wm_we,
    input logic [COEF_W-1:0] coef_idx,
    input logic              block_done,
    input logic              frame_done
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ld_row, row_start, col_start, coef_cap, wm_we})); // R2
    AST_ROW_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) row_start |-> $past(ld_row)); // R3
    AST_ROW_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) row_start |=> !row_start); // R3
    AST_COL_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n) col_start |-> (row_idx == '0)); // R4
    AST_COL_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) col_start |=> !col_start); // R6
    AST_CAP_AFTER_COL_DONE: assert property (@(posedge clk) disable iff (!rst_n) coef_cap |-> $past(col_done)); // R7
    AST_WE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) wm_we |-> $past(coef_cap || wm_we)); // R8
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (wm_we && $past(wm_we)) |-> (coef_idx == COEF_W'($past(coef_idx) + 1'b1))); // R8
    AST_BLOCK_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n) block_done |-> (wm_we && coef_idx == COEF_W'(COEFS - 1))); // R9
    AST_FRAME_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> block_done); // R10

endmodule

bind wm_blk_seq wm_blk_seq_chk #(
    .COEFS  (COEFS),
    .COEF_W (COEF_W),
    .ROW_W  (ROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .col_done   (col_done),
    .ld_row     (ld_row),
    .row_idx    (row_idx),
    .row_start  (row_start),
    .col_start  (col_start),
    .coef_cap   (coef_cap),
    .wm_we      (wm_we),
    .coef_idx   (coef_idx),
    .block_done (block_done),
    .frame_done (frame_done)
);

// File: tb/wm_blk_seq_tb.sv
`timescale 1ns/1ps
module wm_blk_seq_tb;

    localparam int ROWS  = 8;
    localparam int COEFS = 64;
    localparam int BLK_W = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       src_valid;
    logic       row_done;
    logic       col_done;
    logic [3:0] frame_blocks;
    logic       ld_row;
    logic [2:0] row_idx;
    logic       row_start;
    logic       col_start;
    logic       coef_cap;
    logic       wm_we;
    logic [5:0] coef_idx;
    logic       block_done;
    logic       frame_done;

    int nvec = 0;
    int nerr = 0;
    int fcnt = 0;

    always #2.5 clk = ~clk;

    wm_blk_seq #(.ROWS(ROWS), .COEFS(COEFS), .BLK_W(BLK_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_valid    (src_valid),
        .row_done     (row_done),
        .col_done     (col_done),
        .frame_blocks (frame_blocks),
        .ld_row       (ld_row),
        .row_idx      (row_idx),
        .row_start    (row_start),
        .col_start    (col_start),
        .coef_cap     (coef_cap),
        .wm_we        (wm_we),
        .coef_idx     (coef_idx),
        .block_done   (block_done),
        .frame_done   (frame_done)
    );

    // order: ld_row, row_start, col_start, coef_cap, wm_we, block_done, frame_done
    function automatic int strobes();
        return int'({ld_row, row_start, col_start, coef_cap, wm_we, block_done, frame_done});
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_block(input int b, input int fb);
        int fl;
        fl = (fb == 0) ? (1 << BLK_W) : fb;
        for (int r = 0; r < ROWS; r++) begin
            int d0;
            int dr;
            d0 = (b + r) % 3;
            dr = (b * 3 + r) % 4;
            for (int i = 0; i < d0; i++) begin
                @(negedge clk);
                src_valid = 1'b0; row_done = (i == 0); col_done = 1'b1;
                #1;
                chk("R2 idle load strobes", strobes(), 0);
                chk("R5 row index held against stray done", int'(row_idx), r);
            end
            @(negedge clk);
            src_valid = 1'b1; row_done = 1'b0; col_done = 1'b0;
            #1;
            chk("R2 ld_row", strobes(), 7'b1000000);
            chk("R2 row_idx", int'(row_idx), r);
            @(negedge clk);
            src_valid = 1'b0; row_done = 1'b1;
            #1;
            chk("R3 row_start", strobes(), 7'b0100000);
            for (int j = 0; j < dr; j++) begin
                @(negedge clk);
                row_done = 1'b0;
                #1;
                chk("R4 row wait quiet", strobes(), 0);
                chk("R5 stray done in ROW_GO ignored", int'(row_idx), r);
            end
            @(negedge clk);
            row_done = 1'b1;
            #1;
            chk("R4 row wait at done", strobes(), 0);
        end
        @(negedge clk);
        row_done = 1'b0;
        #1;
        chk("R6 col_start", strobes(), 7'b0010000);
        chk("R4 row_idx wrapped", int'(row_idx), 0);
        for (int j = 0; j <= b % 3; j++) begin
            @(negedge clk);
            col_done = 1'b0; row_done = (j == 0);
            #1;
            chk("R6 col wait quiet", strobes(), 0);
        end
        @(negedge clk);
        col_done = 1'b1; row_done = 1'b0;
        #1;
        chk("R6 col wait at done", strobes(), 0);
        @(negedge clk);
        col_done = 1'b0;
        #1;
        chk("R7 coef_cap", strobes(), 7'b0001000);
        for (int k = 0; k < COEFS; k++) begin
            bit last;
            bit fd;
            last = (k == COEFS - 1);
            fd   = last && (fcnt + 1 == fl);
            @(negedge clk);
            col_done = (k == 5);
            #1;
            chk("R8 other strobes low", strobes() >> 3, 0);
            chk("R8 wm_we", int'(wm_we), 1);
            chk("R8 coef_idx", int'(coef_idx), k);
            chk("R9 block_done", int'(block_done), int'(last));
            chk("R10 frame_done", int'(frame_done), int'(fd));
        end
        fcnt = (fcnt + 1 == fl) ? 0 : fcnt + 1;
        @(negedge clk);
        col_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int b;
        rst_n = 1'b0; src_valid = 1'b0; row_done = 1'b0; col_done = 1'b0;
        frame_blocks = 4'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset strobes", strobes(), 0);
        chk("R1 reset row_idx", int'(row_idx), 0);
        chk("R1 reset coef_idx", int'(coef_idx), 0);
        b = 0;
        for (int n = 0; n < 3; n++) begin run_block(b, 3); b++; end
        frame_blocks = 4'd2;
        for (int n = 0; n < 4; n++) begin run_block(b, 2); b++; end
        frame_blocks = 4'd1;
        for (int n = 0; n < 2; n++) begin run_block(b, 1); b++; end
        frame_blocks = 4'd0;
        for (int n = 0; n < 16; n++) begin run_block(b, 0); b++; end
        #1;
        chk("R9 back in load after block", strobes(), 0);
        chk("R9 row_idx after block", int'(row_idx), 0);
        finish_run();
    end

endmodule